// File: doc/BRIEF.md
# NAND Flash Page Sequencer

This block is the host-side engine for a serial-access flash device whose commands, address bytes and data words share one 16-bit bus. A host hands it page-level requests on a valid/ready port. Five operations are available: read a whole page, read only the spare words of a page, program a page, erase a page, and fetch the device status word. For each request the block issues the command and address cycles, waits while the device reports busy, then moves words between the device and the host's read or write stream. It finishes with a one-cycle completion pulse that carries a pass/fail flag.

A page holds 256 data words followed by 8 spare words. A whole-page read runs through the spare words without a second command. The spare-only read jumps straight to the spare words. A program always sends all 264 words, so the host must supply its check bits along with the data. After a program or erase, the block reads the device status and raises the error flag on a reported failure, so the host can move the data to another page. A busy interval longer than a set limit aborts the operation with an error. At power-up the block sends a reset command and accepts no request until the device is ready.

Top module: `nand_page_seq`

## Requirements
- R1: After reset release the block issues one command cycle with byte 0xFF. It holds req_ready_o low until the device busy input has dropped.
- R2: Op code 0 (page read) issues command 0x00, then three address cycles carrying page bits [7:0], [15:8] and [23:16] in that order. It then waits for busy to drop and delivers 264 words in order, device word 0 to 263, and completes with err_o=0.
- R3: Op code 1 (spare read) issues command 0x50 and the same three address cycles. It then delivers exactly 8 words, which are device words 256 to 263, and completes with err_o=0.
- R4: Op code 2 (program) issues command 0x80 and three address cycles. It then takes exactly 264 host words onto the bus, issues 0x10, waits for busy to drop, issues status command 0x70 and reads one status word. err_o equals bit 0 of that word.
- R5: Op code 3 (erase) issues 0x60, three address cycles and 0xD0. It then waits for busy to drop, issues 0x70 and reads one status word. err_o equals bit 0 of that word.
- R6: Op code 4 (status) issues 0x70, returns the next device word to the host unchanged, and completes with err_o=0.
- R7: If busy stays high for TIMEOUT_CYC cycles of a wait, the operation ends with done_o and err_o=1, and no data words move.
- R8: With rdata_ready_i low, the current word is held and not counted. With wdata_valid_i low, nothing is written. No word is lost or repeated under backpressure.
- R9: A read strobe is never issued while the device is busy.
- R10: done_o is high for exactly one cycle. req_ready_o is high only when idle, and the next request can be taken in the cycle after done_o.
- R11: Op codes 5 to 7 cause no bus cycle at all and complete with err_o=1.
- R12: Every read request, including one to the same page as before, issues its own read command and goes through its own busy wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Block idle, request taken when valid |
| req_op_i | input | 3 | Operation code (see R2 to R6, R11) |
| req_page_i | input | 24 | Page address |
| wdata_valid_i | input | 1 | Program word offered by host |
| wdata_ready_o | output | 1 | Program word accepted |
| wdata_i | input | 16 | Program word |
| rdata_valid_o | output | 1 | Read word available |
| rdata_ready_i | input | 1 | Host takes read word |
| rdata_o | output | 16 | Read word |
| done_o | output | 1 | Operation complete pulse |
| err_o | output | 1 | Failure flag, valid with done_o |
| fl_cmd_o | output | 1 | Bus cycle carries a command |
| fl_adr_o | output | 1 | Bus cycle carries an address byte |
| fl_wr_o | output | 1 | Write strobe for the current bus cycle |
| fl_rd_o | output | 1 | Read strobe, advances device word pointer |
| fl_dq_o | output | 16 | Bus value driven to device |
| fl_dq_i | input | 16 | Bus value from device |
| fl_busy_i | input | 1 | Device busy |

## Verification
The hardest state to reach is the busy timeout, because a well-behaved device always drops busy. The bench's device model has a switch that pins busy high after the address phase of a read. The bench then confirms that the abort arrives with the error flag and without any data word. A device-reported program or erase failure is reached in a similar way: the model's status word is loaded with bit 0 set before the request. Backpressure is applied every third cycle so that stalls fall on both the first and the last word of each stream.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
  typedef enum logic [2:0] {
    OP_READ   = 3'd0,
    OP_SPARE  = 3'd1,
    OP_PROG   = 3'd2,
    OP_ERASE  = 3'd3,
    OP_STATUS = 3'd4,
    OP_RESET  = 3'd5
  } op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_CMD, S_ADR, S_WDATA, S_CMD2, S_GAP,
    S_WAIT, S_STCMD, S_STRD, S_RDATA, S_DONE
  } state_e;
endpackage

// File: rtl/nand_word_ctr.sv
module nand_word_ctr #(
  parameter int CW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  input  logic [CW-1:0] lim_i,
  output logic          last_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + CW'(1);
  end

  assign last_o = (cnt_q == lim_i - CW'(1));

  p_no_overrun_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |-> (cnt_q < lim_i));
endmodule

// File: rtl/nand_busy_timer.sv
module nand_busy_timer #(
  parameter int TIMEOUT_CYC = 4096
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expired_o
);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else             cnt_q <= cnt_q + TW'(1);
  end

  assign expired_o = run_i && (cnt_q == TW'(TIMEOUT_CYC - 1));

  // needs TIMEOUT_CYC >= 2
  p_expire_after_run_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expired_o |-> $past(run_i));
endmodule

// File: rtl/nand_page_seq.sv
module nand_page_seq
  import nand_seq_pkg::*;
#(
  parameter int DATA_WORDS  = 256,
  parameter int SPARE_WORDS = 8,
  parameter int ADDR_CYCLES = 3,
  parameter int TIMEOUT_CYC = 4096,
  parameter int FAIL_BIT    = 0,
  parameter logic [7:0] CMD_RD1  = 8'h00,
  parameter logic [7:0] CMD_RD2  = 8'h50,
  parameter logic [7:0] CMD_PRG1 = 8'h80,
  parameter logic [7:0] CMD_PRG2 = 8'h10,
  parameter logic [7:0] CMD_ERS1 = 8'h60,
  parameter logic [7:0] CMD_ERS2 = 8'hD0,
  parameter logic [7:0] CMD_STAT = 8'h70,
  parameter logic [7:0] CMD_RST  = 8'hFF
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  output logic        req_ready_o,
  input  logic [2:0]  req_op_i,
  input  logic [8*ADDR_CYCLES-1:0] req_page_i,
  input  logic        wdata_valid_i,
  output logic        wdata_ready_o,
  input  logic [15:0] wdata_i,
  output logic        rdata_valid_o,
  input  logic        rdata_ready_i,
  output logic [15:0] rdata_o,
  output logic        done_o,
  output logic        err_o,
  output logic        fl_cmd_o,
  output logic        fl_adr_o,
  output logic        fl_wr_o,
  output logic        fl_rd_o,
  output logic [15:0] fl_dq_o,
  input  logic [15:0] fl_dq_i,
  input  logic        fl_busy_i
);
  localparam int PAGE_WORDS = DATA_WORDS + SPARE_WORDS;
  localparam int CW = $clog2(PAGE_WORDS + 1);
  localparam int PW = 8 * ADDR_CYCLES;
  localparam int AW = $clog2(ADDR_CYCLES + 1);

  state_e        state_q;
  op_e           op_q;
  logic [PW-1:0] page_q;
  logic [AW-1:0] adr_q;
  logic          err_q;
  logic [CW-1:0] lim;
  logic          xfer, ctr_last, expired;
  logic [7:0]    cmd1, cmd2;
  int unsigned   sel;

  always_comb begin
    unique case (op_q)
      OP_READ, OP_PROG: lim = CW'(PAGE_WORDS);
      OP_SPARE:         lim = CW'(SPARE_WORDS);
      default:          lim = CW'(1);
    endcase
    unique case (op_q)
      OP_READ:   cmd1 = CMD_RD1;
      OP_SPARE:  cmd1 = CMD_RD2;
      OP_PROG:   cmd1 = CMD_PRG1;
      OP_ERASE:  cmd1 = CMD_ERS1;
      OP_STATUS: cmd1 = CMD_STAT;
      default:   cmd1 = CMD_RST;
    endcase
    cmd2 = (op_q == OP_PROG) ? CMD_PRG2 : CMD_ERS2;
  end

  assign xfer = (state_q == S_RDATA && rdata_ready_i) ||
                (state_q == S_WDATA && wdata_valid_i);

  nand_word_ctr #(.CW(CW)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (state_q != S_RDATA && state_q != S_WDATA),
    .inc_i  (xfer),
    .lim_i  (lim),
    .last_o (ctr_last)
  );

  nand_busy_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (state_q == S_WAIT && fl_busy_i),
    .expired_o (expired)
  );

  // bus side
  assign fl_cmd_o = (state_q == S_CMD) || (state_q == S_CMD2) || (state_q == S_STCMD);
  assign fl_adr_o = (state_q == S_ADR);
  assign fl_wr_o  = fl_cmd_o || fl_adr_o || (state_q == S_WDATA && wdata_valid_i);
  assign fl_rd_o  = (state_q == S_RDATA && rdata_ready_i) || (state_q == S_STRD);
  assign sel      = 8 * int'(adr_q);

  always_comb begin
    unique case (state_q)
      S_CMD:   fl_dq_o = {8'h00, cmd1};
      S_CMD2:  fl_dq_o = {8'h00, cmd2};
      S_STCMD: fl_dq_o = {8'h00, CMD_STAT};
      S_ADR:   fl_dq_o = {8'h00, page_q[sel +: 8]};
      S_WDATA: fl_dq_o = wdata_i;
      default: fl_dq_o = 16'h0000;
    endcase
  end

  // host side
  assign req_ready_o   = (state_q == S_IDLE);
  assign wdata_ready_o = (state_q == S_WDATA);
  assign rdata_valid_o = (state_q == S_RDATA);
  assign rdata_o       = fl_dq_i;
  assign done_o        = (state_q == S_DONE);
  assign err_o         = done_o && err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_CMD;
      op_q    <= OP_RESET;
      page_q  <= '0;
      adr_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: if (req_valid_i) begin
          page_q <= req_page_i;
          adr_q  <= '0;
          if (req_op_i > 3'd4) begin
            err_q   <= 1'b1;
            state_q <= S_DONE;
          end else begin
            err_q   <= 1'b0;
            op_q    <= op_e'(req_op_i);
            state_q <= S_CMD;
          end
        end
        S_CMD: begin
          if (op_q == OP_RESET)       state_q <= S_GAP;
          else if (op_q == OP_STATUS) state_q <= S_RDATA;
          else                        state_q <= S_ADR;
        end
        S_ADR: begin
          adr_q <= adr_q + AW'(1);
          if (adr_q == AW'(ADDR_CYCLES - 1)) begin
            if (op_q == OP_PROG)       state_q <= S_WDATA;
            else if (op_q == OP_ERASE) state_q <= S_CMD2;
            else                       state_q <= S_GAP;
          end
        end
        S_WDATA: if (xfer && ctr_last) state_q <= S_CMD2;
        S_CMD2:  state_q <= S_GAP;
        S_GAP:   state_q <= S_WAIT;  // device raises busy here
        S_WAIT: begin
          if (!fl_busy_i) begin
            if (op_q == OP_READ || op_q == OP_SPARE)      state_q <= S_RDATA;
            else if (op_q == OP_PROG || op_q == OP_ERASE) state_q <= S_STCMD;
            else                                          state_q <= S_IDLE;
          end else if (expired) begin
            err_q   <= 1'b1;
            state_q <= (op_q == OP_RESET) ? S_IDLE : S_DONE;
          end
        end
        S_STCMD: state_q <= S_STRD;
        S_STRD: begin
          err_q   <= fl_dq_i[FAIL_BIT];
          state_q <= S_DONE;
        end
        S_RDATA: if (xfer && ctr_last) state_q <= S_DONE;
        S_DONE:  state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  p_one_strobe_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({fl_rd_o, fl_wr_o}));
  p_latch_kind_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fl_cmd_o || fl_adr_o) |-> (fl_wr_o && !(fl_cmd_o && fl_adr_o)));
  p_no_read_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_rd_o |-> !fl_busy_i);
  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && req_ready_o));
  p_ready_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (!fl_wr_o && !fl_rd_o && !rdata_valid_o));
  p_rd_stall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_valid_o && !rdata_ready_i) |=> rdata_valid_o);
  p_wr_stall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wdata_ready_o && !wdata_valid_i) |=> (wdata_ready_o && !fl_cmd_o));
  p_bad_op_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_ready_o && req_valid_i && req_op_i > 3'd4) |=> (done_o && err_o && !fl_wr_o));
endmodule

// File: tb/sim_nand_page_seq.sv
module sim_nand_page_seq;
  localparam int CLK_PERIOD = 10;
  localparam int TMO = 64;
  localparam int PWORDS = 264;
  localparam logic [7:0] C_RD1 = 8'h00, C_RD2 = 8'h50, C_PRG2 = 8'h10,
                         C_ERS2 = 8'hD0, C_STAT = 8'h70, C_RST = 8'hFF, C_PRG1 = 8'h80;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ready_o;
  logic [2:0] req_op = 0;
  logic [23:0] req_page = 0;
  logic wdata_valid = 0, wdata_ready_o;
  logic [15:0] wdata = 0;
  logic rdata_valid_o, rdata_ready = 0;
  logic [15:0] rdata_o;
  logic done_o, err_o, fl_cmd_o, fl_adr_o, fl_wr_o, fl_rd_o, fl_busy_i;
  logic [15:0] fl_dq_o, fl_dq_i;

  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_page_seq #(.TIMEOUT_CYC(TMO)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready_o), .req_op_i(req_op), .req_page_i(req_page),
    .wdata_valid_i(wdata_valid), .wdata_ready_o(wdata_ready_o), .wdata_i(wdata),
    .rdata_valid_o(rdata_valid_o), .rdata_ready_i(rdata_ready), .rdata_o(rdata_o),
    .done_o(done_o), .err_o(err_o),
    .fl_cmd_o(fl_cmd_o), .fl_adr_o(fl_adr_o), .fl_wr_o(fl_wr_o), .fl_rd_o(fl_rd_o),
    .fl_dq_o(fl_dq_o), .fl_dq_i(fl_dq_i), .fl_busy_i(fl_busy_i)
  );

  function automatic logic [15:0] pat(input logic [23:0] pg, input int idx);
    return (pg[15:0] * 16'd3) ^ (16'(idx) * 16'h0107);
  endfunction
  function automatic logic [15:0] wpat(input logic [23:0] pg, input int idx);
    return 16'hA5A5 ^ (16'(idx) * 16'h0209) ^ pg[15:0];
  endfunction
  function automatic logic [15:0] wxor(input logic [23:0] pg);
    logic [15:0] x = 16'h0;
    for (int i = 0; i < PWORDS; i++) x ^= wpat(pg, i);
    return x;
  endfunction
  function automatic int rc_for(input logic [2:0] op);
    return (op == 3'd0) ? PWORDS : (op == 3'd1) ? 8 : (op == 3'd4) ? 1 : 0;
  endfunction

  // device model
  logic busy = 0, busy_hold = 0, stat_fail = 0, stat_mode = 0;
  int busy_len = 20, busy_left = 0, busy_starts = 0, ptr = 0, adr_n = 0, wr_words = 0;
  logic [7:0] last_cmd = 8'h00, prev_cmd = 8'h00;
  logic [23:0] m_addr = 0;
  logic [15:0] wr_xor = 0;
  logic start;

  assign fl_busy_i = busy;
  assign fl_dq_i = stat_mode ? (16'h00C0 | {15'd0, stat_fail}) : pat(m_addr, ptr);
  assign start = fl_wr_o && ((fl_cmd_o && (fl_dq_o[7:0] == C_RST || fl_dq_o[7:0] == C_PRG2 ||
                 fl_dq_o[7:0] == C_ERS2)) ||
                 (fl_adr_o && adr_n == 2 && (last_cmd == C_RD1 || last_cmd == C_RD2)));

  always @(posedge clk) begin
    if (!rst_n) begin
      busy <= 0; busy_starts <= 0; stat_mode <= 0; ptr <= 0; adr_n <= 0;
    end else begin
      if (start) begin
        busy <= 1; busy_left <= busy_len; busy_starts <= busy_starts + 1;
      end else if (busy && !busy_hold) begin
        if (busy_left <= 1) busy <= 0;
        busy_left <= busy_left - 1;
      end
      if (fl_wr_o && fl_cmd_o) begin
        prev_cmd <= last_cmd; last_cmd <= fl_dq_o[7:0]; adr_n <= 0;
        stat_mode <= (fl_dq_o[7:0] == C_STAT);
        if (fl_dq_o[7:0] == C_RD1) ptr <= 0;
        if (fl_dq_o[7:0] == C_RD2) ptr <= 256;
        if (fl_dq_o[7:0] == C_PRG1) begin wr_words <= 0; wr_xor <= 0; end
      end else if (fl_wr_o && fl_adr_o) begin
        m_addr[8*adr_n +: 8] <= fl_dq_o[7:0]; adr_n <= adr_n + 1;
      end else if (fl_wr_o) begin
        wr_words <= wr_words + 1; wr_xor <= wr_xor ^ fl_dq_o;
      end
      if (fl_rd_o && !stat_mode) ptr <= ptr + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [2:0] op, input logic [23:0] page, input bit bp,
                        input bit exp_err, input int exp_rc, input string tag);
    int rcnt = 0, bad = 0, widx = 0, cyc = 0, rdbusy = 0, bs0;
    bit got = 0, stall;
    logic e = 0;
    logic [15:0] expw;
    bs0 = busy_starts;
    while (!req_ready_o) @(negedge clk);
    req_valid = 1; req_op = op; req_page = page;
    @(negedge clk);
    req_valid = 0;
    while (!got && cyc < 3000) begin
      stall = bp && (cyc % 3 == 1);
      wdata_valid = !stall && widx < PWORDS;
      wdata = wpat(page, widx);
      rdata_ready = !stall;
      #1;
      if (fl_rd_o && fl_busy_i) rdbusy++;
      if (wdata_valid && wdata_ready_o) widx++;
      if (rdata_valid_o && rdata_ready) begin
        expw = (op == 3'd4) ? (16'h00C0 | {15'd0, stat_fail}) :
               pat(page, (op == 3'd1) ? 256 + rcnt : rcnt);
        if (rdata_o !== expw) bad++;
        rcnt++;
      end
      if (done_o) begin got = 1; e = err_o; end
      cyc++;
      @(negedge clk);
    end
    wdata_valid = 0; rdata_ready = 0;
    chk(got, {tag, " R10 completion"}, got, 1);
    chk(!done_o && req_ready_o, {tag, " R10 single done pulse"}, done_o, 0);
    chk(e == exp_err, {tag, " R4/R5/R7 err flag"}, e, exp_err);
    chk(rcnt == exp_rc, {tag, " R2/R3/R8 word count"}, rcnt, exp_rc);
    chk(bad == 0, {tag, " R2/R3/R6 word values"}, bad, 0);
    chk(rdbusy == 0, {tag, " R9 read while busy"}, rdbusy, 0);
    if (exp_rc > 1) begin
      chk(last_cmd == ((op == 3'd0) ? C_RD1 : C_RD2), {tag, " R2/R3 read command"}, last_cmd, op);
      chk(m_addr == page, {tag, " R2 address bytes"}, m_addr, page);
      chk(busy_starts == bs0 + 1, {tag, " R12 fresh busy wait"}, busy_starts, bs0 + 1);
    end
    if (op == 3'd2 && !busy_hold) begin
      chk(wr_words == PWORDS, {tag, " R4 words written"}, wr_words, PWORDS);
      chk(wr_xor == wxor(page), {tag, " R4 data incl spare"}, wr_xor, wxor(page));
      chk(prev_cmd == C_PRG2 && last_cmd == C_STAT, {tag, " R4 confirm+status"}, {prev_cmd, last_cmd}, {C_PRG2, C_STAT});
      chk(m_addr == page, {tag, " R4 address"}, m_addr, page);
    end
    if (op == 3'd3) begin
      chk(prev_cmd == C_ERS2 && last_cmd == C_STAT, {tag, " R5 confirm+status"}, {prev_cmd, last_cmd}, {C_ERS2, C_STAT});
      chk(m_addr == page, {tag, " R5 address"}, m_addr, page);
    end
    if (op == 3'd4) chk(last_cmd == C_STAT, {tag, " R6 status command"}, last_cmd, C_STAT);
  endtask

  typedef struct packed {
    logic [2:0]  op;
    logic [23:0] page;
    logic        bp;
    logic        fail;
    logic        exp_err;
  } vec_t;

  localparam vec_t VEC [10] = '{
    '{3'd0, 24'h000012, 1'b0, 1'b0, 1'b0},
    '{3'd0, 24'h0A0B0C, 1'b1, 1'b0, 1'b0},
    '{3'd1, 24'h000031, 1'b0, 1'b0, 1'b0},
    '{3'd1, 24'h123456, 1'b1, 1'b0, 1'b0},
    '{3'd2, 24'h000200, 1'b0, 1'b0, 1'b0},
    '{3'd2, 24'h000201, 1'b1, 1'b1, 1'b1},
    '{3'd3, 24'h000300, 1'b0, 1'b0, 1'b0},
    '{3'd3, 24'h000301, 1'b0, 1'b1, 1'b1},
    '{3'd4, 24'h000000, 1'b0, 1'b1, 1'b0},
    '{3'd4, 24'h000000, 1'b1, 1'b0, 1'b0}
  };

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog (all requirements): actual hung expected finish");
    summary();
    $finish;
  end

  initial begin
    int n, bs, lc;
    busy_len = 20;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 power-up
    repeat (5) @(negedge clk);
    chk(req_ready_o == 0, "R1 not ready while device busy", req_ready_o, 0);
    chk(last_cmd == C_RST, "R1 reset command", last_cmd, C_RST);
    n = 5;
    while (!req_ready_o && n < 500) begin @(negedge clk); n++; end
    chk(req_ready_o && n >= 20, "R1 ready after busy", n, 20);
    chk(busy_starts == 1, "R1 single reset", busy_starts, 1);

    busy_len = 12;
    foreach (VEC[i]) begin
      stat_fail = VEC[i].fail;
      run_op(VEC[i].op, VEC[i].page, VEC[i].bp, VEC[i].exp_err, rc_for(VEC[i].op),
             $sformatf("vec%0d", i));
    end

    // R12 same page twice
    run_op(3'd0, 24'h000012, 1'b0, 1'b0, PWORDS, "R12 repeat a");
    run_op(3'd0, 24'h000012, 1'b0, 1'b0, PWORDS, "R12 repeat b");

    // R7 busy timeout
    busy_hold = 1;
    run_op(3'd0, 24'h000777, 1'b0, 1'b1, 0, "R7 timeout");
    busy_hold = 0;
    repeat (30) @(negedge clk);

    // R11 illegal op
    bs = busy_starts; lc = int'(last_cmd);
    run_op(3'd6, 24'h000001, 1'b0, 1'b1, 0, "R11 bad op");
    chk(busy_starts == bs && int'(last_cmd) == lc, "R11 no bus cycles", last_cmd, lc);

    // device still usable afterwards
    stat_fail = 0;
    run_op(3'd1, 24'h0000AA, 1'b1, 1'b0, 8, "R3 after abort");

    summary();
    $finish;
  end
endmodule